// File: doc/BRIEF.md
# Method Write Dispatcher with Macro Capture

This block sits behind a command processor and consumes its stream of method writes. Each write carries a method index, a 32-bit value and a count of the parameters that still follow it in the command stream. The block sorts each write into one of two regions.

Indices below the macro threshold (0xE00) address a small register file. The value is stored there. A few configured indices also fire a one-cycle side-effect strobe.

Indices at or above the threshold are macro triggers. An even index opens a capture. The value written there and every value written to the matching odd argument index are collected into a parameter buffer. When a write arrives with a remaining count of zero, the block presents a macro-call request carrying the macro slot, the word count and the words. A separate upload port marks which slots hold code. Calls to empty slots, malformed call sequences, out-of-range register indices and buffer overflow each set their own sticky error bit. The macro code itself is not executed here; only the dispatch handshake toward the engine that runs it is provided.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset, `call_valid` is 0, `err_o` is 0, every register reads 0, `trig_o` is 0, `wr_ready` is 1 and no macro slot is marked loaded.
- R2: A write accepted while no capture is active, with an index below 64, stores its value at that index. The value can be read combinationally through `rd_addr`/`rd_data` from the cycle after the accepting edge.
- R3: A stored write to index 12, 21 or 40 pulses `trig_o` bit 0, 1 or 2 respectively for exactly the one cycle after the accepting edge. Other writes leave `trig_o` at 0.
- R4: A write with an index from 64 to 0xDFF, with no capture active, is dropped and sets `err_o` bit 1.
- R5: An even index of 0xE00 or above, with no capture active, opens a capture for slot (index − 0xE00)/2. Its value becomes parameter word 0. Each later write to that index plus one appends its value. A write whose remaining count is 0 closes the capture, and the next capture again starts at word 0.
- R6: When a capture closes for a loaded slot, `call_valid` rises in the next cycle. In that same cycle `call_id` carries the slot, `call_count` carries the word count, and word k sits at `call_params[32k+31:32k]`. All of these stay stable, and `wr_ready` stays 0 so that no write is accepted, until the cycle after `call_ack`.
- R7: A pulse on `upl_valid` marks slot `upl_slot` as loaded until reset.
- R8: A capture that closes on an unloaded slot, or an even trigger index whose slot is 16 or above, produces no call and sets `err_o` bit 2. The capture state is cleared.
- R9: An odd trigger index written with no capture active is dropped and sets `err_o` bit 0.
- R10: While a capture is active, any write other than the argument index is dropped. It makes no register store and no append. It sets `err_o` bit 0, and the capture continues.
- R11: Words beyond the 8th in one capture are dropped, `err_o` bit 3 is set, and the call reports a count of 8.
- R12: Every `err_o` bit, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Method write offered |
| wr_ready | output | 1 | Block accepts a write this cycle |
| wr_method | input | 13 | Method index |
| wr_data | input | 32 | Method value |
| wr_remain | input | 8 | Parameters still following this write |
| upl_valid | input | 1 | Macro code upload done for a slot |
| upl_slot | input | 4 | Slot that received code |
| rd_addr | input | 6 | Register file read index |
| rd_data | output | 32 | Register file read value |
| trig_o | output | 3 | Side-effect strobes, one per configured index |
| call_valid | output | 1 | Macro-call request pending |
| call_id | output | 4 | Slot of the requested macro |
| call_count | output | 4 | Number of parameter words |
| call_params | output | 256 | Parameter words, word k at bits 32k+31:32k |
| call_ack | input | 1 | Engine takes the pending call |
| err_o | output | 4 | Sticky errors: 0 sequence, 1 range, 2 unloaded, 3 overflow |

## Verification
The bench first sweeps register stores and strobes with a vector table. It then goes after the capture corner cases.

- A capture that ends on its very first word must report a count of 1. A design that counted only argument writes would report 0.
- A register write slipped into an open capture must not land in the register file. A leaky design would both store it and corrupt the sequence.
- The tenth word of an over-long capture must be dropped with the count pinned at 8. A design without the guard would wrap the count or overwrite word 0.
- Writes offered while a call waits for acknowledge must stall. A design that ignored `wr_ready` would store them.
- The unloaded-slot and odd-start cases must never raise `call_valid`.

// File: rtl/cdx_pkg.sv
package cdx_pkg;
  localparam int ERR_SEQ   = 0;
  localparam int ERR_RANGE = 1;
  localparam int ERR_UNL   = 2;
  localparam int ERR_OVF   = 3;
  localparam int ERR_W     = 4;

  // trigger index of a macro slot
  function automatic int unsigned entry_index(int unsigned base, int unsigned slot);
    return base + 2 * slot;
  endfunction

  // argument port index of a macro slot
  function automatic int unsigned arg_index(int unsigned base, int unsigned slot);
    return entry_index(base, slot) + 1;
  endfunction
endpackage

// File: rtl/cdx_regfile.sv
module cdx_regfile #(
  parameter int MIDX_W    = 13,
  parameter int DATA_W    = 32,
  parameter int REG_DEPTH = 64,
  parameter int NUM_TRIG  = 3,
  parameter logic [NUM_TRIG*MIDX_W-1:0] TRIG_LIST = {13'd40, 13'd21, 13'd12},
  localparam int RA_W = $clog2(REG_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [RA_W-1:0]     waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [RA_W-1:0]     raddr,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_TRIG-1:0] trig_o
);
  logic [DATA_W-1:0]   mem [REG_DEPTH];
  logic [NUM_TRIG-1:0] trig_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig
    assign trig_hit[k] = we && (MIDX_W'(waddr) == TRIG_LIST[k*MIDX_W +: MIDX_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_o <= '0;
    else        trig_o <= trig_hit;
  end

  // R2
  reg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
  // R3
  trig_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_o));
  // R3
  trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_hit) |=> (|trig_o));
endmodule

// File: rtl/cdx_slot_tbl.sv
module cdx_slot_tbl #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upl_valid,
  input  logic [SLOT_W-1:0]    upl_slot,
  output logic [NUM_SLOTS-1:0] loaded
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         loaded <= '0;
    else if (upl_valid) loaded[upl_slot] <= 1'b1;
  end

  // R7
  slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upl_valid |=> loaded[$past(upl_slot)]);
  // R7
  slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&loaded) |=> (&loaded));
endmodule

// File: rtl/cdx_capture.sv
module cdx_capture #(
  parameter int MIDX_W     = 13,
  parameter int DATA_W     = 32,
  parameter int REM_W      = 8,
  parameter int unsigned MACRO_BASE = 'hE00,
  parameter int NUM_SLOTS  = 16,
  parameter int PBUF_DEPTH = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(PBUF_DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc,
  input  logic [MIDX_W-1:0]            method,
  input  logic [DATA_W-1:0]            data,
  input  logic [REM_W-1:0]             remain,
  input  logic [NUM_SLOTS-1:0]         loaded,
  input  logic                         call_ack,
  output logic                         pass_reg,
  output logic                         ev_seq,
  output logic                         ev_unl,
  output logic                         ev_ovf,
  output logic                         call_valid,
  output logic [SLOT_W-1:0]            call_id,
  output logic [CNT_W-1:0]             call_count,
  output logic [PBUF_DEPTH*DATA_W-1:0] call_params
);
  logic              busy_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] pbuf_q [PBUF_DEPTH];

  logic              is_mac, in_slot_ok, arg_port;
  logic [MIDX_W-1:0] off;
  logic [SLOT_W-1:0] in_slot, cur_slot;
  logic              start, bad_slot, odd_start, wrong_port, cont;
  logic              take, room, last, fire;
  logic [CNT_W-1:0]  cnt_nx;

  assign is_mac     = 32'(method) >= MACRO_BASE;
  assign off        = method - MIDX_W'(MACRO_BASE);
  assign in_slot_ok = (32'(off) >> 1) < NUM_SLOTS;
  assign in_slot    = off[SLOT_W:1];
  assign arg_port   = 32'(method) == cdx_pkg::arg_index(MACRO_BASE, 32'(slot_q));

  assign start      = acc & ~busy_q & is_mac & ~off[0] &  in_slot_ok;
  assign bad_slot   = acc & ~busy_q & is_mac & ~off[0] & ~in_slot_ok;
  assign odd_start  = acc & ~busy_q & is_mac &  off[0];
  assign wrong_port = acc &  busy_q & ~arg_port;
  assign cont       = acc &  busy_q &  arg_port;
  assign pass_reg   = acc & ~busy_q & ~is_mac;

  assign take     = start | cont;
  assign room     = 32'(cnt_q) < PBUF_DEPTH;
  assign cnt_nx   = room ? cnt_q + 1'b1 : cnt_q;
  assign last     = take & (remain == '0);
  assign cur_slot = busy_q ? slot_q : in_slot;
  assign fire     = last &  loaded[cur_slot];

  assign ev_seq = odd_start | wrong_port;
  assign ev_unl = (last & ~loaded[cur_slot]) | bad_slot;
  assign ev_ovf = take & ~room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < PBUF_DEPTH; i++) pbuf_q[i] <= '0;
    end else begin
      for (int i = 0; i < PBUF_DEPTH; i++)
        if (take && room && 32'(cnt_q) == i) pbuf_q[i] <= data;
      if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (take) begin
        busy_q <= 1'b1;
        slot_q <= cur_slot;
        cnt_q  <= cnt_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_valid  <= 1'b0;
      call_id     <= '0;
      call_count  <= '0;
      call_params <= '0;
    end else if (fire) begin
      call_valid <= 1'b1;
      call_id    <= cur_slot;
      call_count <= cnt_nx;
      for (int i = 0; i < PBUF_DEPTH; i++)
        call_params[i*DATA_W +: DATA_W] <= (room && 32'(cnt_q) == i) ? data : pbuf_q[i];
    end else if (call_ack) begin
      call_valid <= 1'b0;
    end
  end

  // R6
  call_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && !call_ack |=> call_valid && $stable(call_id)
                                && $stable(call_count) && $stable(call_params));
  // R11
  call_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> (call_count != '0) && (32'(call_count) <= PBUF_DEPTH));
  // R5
  close_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q && cnt_q == '0);
  // R8
  no_call_unl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !loaded[cur_slot] && !call_valid) |=> !call_valid);
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch #(
  parameter int MIDX_W     = 13,
  parameter int DATA_W     = 32,
  parameter int REM_W      = 8,
  parameter int REG_DEPTH  = 64,
  parameter int unsigned MACRO_BASE = 'hE00,
  parameter int NUM_SLOTS  = 16,
  parameter int PBUF_DEPTH = 8,
  parameter int NUM_TRIG   = 3,
  parameter logic [NUM_TRIG*MIDX_W-1:0] TRIG_LIST = {13'd40, 13'd21, 13'd12},
  localparam int RA_W   = $clog2(REG_DEPTH),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(PBUF_DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [MIDX_W-1:0]            wr_method,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [REM_W-1:0]             wr_remain,
  input  logic                         upl_valid,
  input  logic [SLOT_W-1:0]            upl_slot,
  input  logic [RA_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_TRIG-1:0]          trig_o,
  output logic                         call_valid,
  output logic [SLOT_W-1:0]            call_id,
  output logic [CNT_W-1:0]             call_count,
  output logic [PBUF_DEPTH*DATA_W-1:0] call_params,
  input  logic                         call_ack,
  output logic [cdx_pkg::ERR_W-1:0]    err_o
);
  import cdx_pkg::*;

  logic                 acc, pass_reg, reg_hit;
  logic                 ev_seq, ev_unl, ev_ovf, ev_range;
  logic [NUM_SLOTS-1:0] loaded;
  logic [ERR_W-1:0]     err_set;

  assign wr_ready = ~call_valid;
  assign acc      = wr_valid & wr_ready;
  assign reg_hit  = pass_reg & (32'(wr_method) < REG_DEPTH);
  assign ev_range = pass_reg & ~reg_hit;

  cdx_capture #(
    .MIDX_W(MIDX_W), .DATA_W(DATA_W), .REM_W(REM_W), .MACRO_BASE(MACRO_BASE),
    .NUM_SLOTS(NUM_SLOTS), .PBUF_DEPTH(PBUF_DEPTH)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .acc(acc), .method(wr_method), .data(wr_data),
    .remain(wr_remain), .loaded(loaded), .call_ack(call_ack),
    .pass_reg(pass_reg), .ev_seq(ev_seq), .ev_unl(ev_unl), .ev_ovf(ev_ovf),
    .call_valid(call_valid), .call_id(call_id), .call_count(call_count),
    .call_params(call_params)
  );

  cdx_regfile #(
    .MIDX_W(MIDX_W), .DATA_W(DATA_W), .REG_DEPTH(REG_DEPTH),
    .NUM_TRIG(NUM_TRIG), .TRIG_LIST(TRIG_LIST)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_hit), .waddr(wr_method[RA_W-1:0]),
    .wdata(wr_data), .raddr(rd_addr), .rdata(rd_data), .trig_o(trig_o)
  );

  cdx_slot_tbl #(.NUM_SLOTS(NUM_SLOTS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .upl_valid(upl_valid), .upl_slot(upl_slot),
    .loaded(loaded)
  );

  always_comb begin
    err_set            = '0;
    err_set[ERR_SEQ]   = ev_seq;
    err_set[ERR_RANGE] = ev_range;
    err_set[ERR_UNL]   = ev_unl;
    err_set[ERR_OVF]   = ev_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= '0;
    else        err_o <= err_o | err_set;
  end

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_o) |=> (|err_o));
  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o[ERR_OVF] |=> err_o[ERR_OVF]);
  // R6
  call_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> $past(acc));
  // R4
  range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range |=> err_o[ERR_RANGE]);
endmodule

// File: tb/test_cmd_dispatch.sv
module test_cmd_dispatch;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_valid = 0;
  logic         wr_ready;
  logic [12:0]  wr_method = '0;
  logic [31:0]  wr_data = '0;
  logic [7:0]   wr_remain = '0;
  logic         upl_valid = 0;
  logic [3:0]   upl_slot = '0;
  logic [5:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [2:0]   trig_o;
  logic         call_valid;
  logic [3:0]   call_id;
  logic [3:0]   call_count;
  logic [255:0] call_params;
  logic         call_ack = 0;
  logic [3:0]   err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_dispatch i_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_method(wr_method), .wr_data(wr_data), .wr_remain(wr_remain),
    .upl_valid(upl_valid), .upl_slot(upl_slot), .rd_addr(rd_addr), .rd_data(rd_data),
    .trig_o(trig_o), .call_valid(call_valid), .call_id(call_id),
    .call_count(call_count), .call_params(call_params), .call_ack(call_ack),
    .err_o(err_o)
  );

  // {index, value}
  localparam logic [44:0] REG_VEC [6] = '{
    {13'd3,  32'hA5A5_0003},
    {13'd12, 32'h1111_000C},
    {13'd21, 32'h2222_0015},
    {13'd40, 32'h4444_0028},
    {13'd63, 32'hFFFF_003F},
    {13'd12, 32'h5555_000C}
  };

  function automatic logic [2:0] want_trig(int idx);
    case (idx)
      12: return 3'b001;
      21: return 3'b010;
      40: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int m, logic [31:0] d, int r);
    @(negedge clk);
    wr_valid = 1; wr_method = 13'(m); wr_data = d; wr_remain = 8'(r);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic upload(int s);
    @(negedge clk);
    upl_valid = 1; upl_slot = 4'(s);
    @(negedge clk);
    upl_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk);
    call_ack = 1;
    @(negedge clk);
    call_ack = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [31:0] word(int k);
    return call_params[k*32 +: 32];
  endfunction

  function automatic int trig_of(int slot);
    return 'hE00 + slot * 2;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd_addr = 6'd5; #1;
    chk("R1 call_valid", call_valid, 0);
    chk("R1 err_o", err_o, 0);
    chk("R1 trig_o", trig_o, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 reg5", rd_data, 0);

    // R2 R3 vector walk
    foreach (REG_VEC[i]) begin
      int idx = int'(REG_VEC[i][44:32]);
      wr(idx, REG_VEC[i][31:0], 0);
      chk("R3 trig", trig_o, want_trig(idx));
      rd_addr = 6'(idx); #1;
      chk("R2 stored", rd_data, REG_VEC[i][31:0]);
    end
    @(negedge clk);
    chk("R3 trig single cycle", trig_o, 0);

    // R4 out-of-range register index
    wr(100, 32'h0BAD, 0);
    chk("R4 range err", err_o, 4'b0010);
    chk("R4 no trig", trig_o, 0);

    // R5 R6 R7 three-word call, stalls while pending
    do_reset();
    upload(1);
    upload(3);
    wr(trig_of(1), 32'hC0DE_0000, 2);
    chk("R5 not yet", call_valid, 0);
    wr(trig_of(1) + 1, 32'hC0DE_0001, 1);
    wr(trig_of(1) + 1, 32'hC0DE_0002, 0);
    chk("R6 valid", call_valid, 1);
    chk("R6 id", call_id, 1);
    chk("R5 count", call_count, 3);
    chk("R5 w0", word(0), 32'hC0DE_0000);
    chk("R5 w1", word(1), 32'hC0DE_0001);
    chk("R5 w2", word(2), 32'hC0DE_0002);
    chk("R6 ready low", wr_ready, 0);
    wr(5, 32'h5555, 0);
    repeat (2) @(negedge clk);
    chk("R6 held", call_valid, 1);
    chk("R6 id held", call_id, 1);
    ack();
    chk("R6 released", call_valid, 0);
    chk("R6 ready high", wr_ready, 1);
    rd_addr = 6'd5; #1;
    chk("R6 stalled write not stored", rd_data, 0);

    // R5 single-word call; R7 slot 3 loaded
    wr(trig_of(3), 32'h0000_0777, 0);
    chk("R7 slot3 call", call_valid, 1);
    chk("R5 id3", call_id, 3);
    chk("R5 count1", call_count, 1);
    chk("R5 w0 single", word(0), 32'h777);
    ack();
    chk("R12 no errs", err_o, 0);

    // R8 unloaded slot
    wr(trig_of(2), 32'h1, 0);
    chk("R8 no call", call_valid, 0);
    chk("R8 err", err_o, 4'b0100);
    // R8 slot beyond table
    do_reset();
    wr(trig_of(16), 32'h2, 0);
    chk("R8 big slot err", err_o, 4'b0100);
    chk("R8 big slot no call", call_valid, 0);

    // R9 odd start
    do_reset();
    upload(3);
    wr(trig_of(3) + 1, 32'h3, 0);
    chk("R9 err", err_o, 4'b0001);
    chk("R9 no call", call_valid, 0);

    // R10 foreign write during capture
    do_reset();
    upload(1);
    wr(trig_of(1), 32'h11, 1);
    wr(3, 32'hDEAD, 0);
    chk("R10 err", err_o, 4'b0001);
    chk("R10 no call", call_valid, 0);
    rd_addr = 6'd3; #1;
    chk("R10 reg untouched", rd_data, 0);
    wr(trig_of(1) + 1, 32'h22, 0);
    chk("R10 call", call_valid, 1);
    chk("R10 count", call_count, 2);
    chk("R10 w1", word(1), 32'h22);
    ack();

    // R11 overflow with 10 words
    do_reset();
    upload(1);
    wr(trig_of(1), 32'd100, 9);
    for (int k = 1; k < 10; k++) wr(trig_of(1) + 1, 32'(100 + k), 9 - k);
    chk("R11 call", call_valid, 1);
    chk("R11 count", call_count, 8);
    chk("R11 w0", word(0), 100);
    chk("R11 w7", word(7), 107);
    chk("R11 err", err_o, 4'b1000);
    ack();
    // R12 sticky across a clean call
    wr(trig_of(1), 32'd5, 0);
    chk("R12 call", call_valid, 1);
    ack();
    chk("R12 sticky", err_o, 4'b1000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule